// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block keeps the exception bookkeeping for a five-stage in-order pipeline made of fetch, decode, execute, memory and writeback. Each pipeline slot holds a valid bit, a fault tag, a cause code and the instruction address. A stage that detects a fault raises its strobe and supplies a code. The offending instruction is then marked and its side effects are suppressed, but it keeps moving down the pipe like a bubble. Nothing is redirected until the marked instruction arrives at writeback.

When a marked instruction sits in writeback, the controller asserts one flush over the four younger slots, blocks a store in the memory slot and steers fetch to the fixed handler entry. In the same cycle it loads the single architectural exception-PC and cause pair. Because only the writeback slot can trigger, the oldest fault in program order always wins, and faults raised by younger instructions are thrown away by the flush. An external interrupt request uses the same path. It is taken only at a writeback slot that holds a valid, unmarked instruction, and that instruction still completes.

Top module: `exc_commit_unit`

## Requirements
- R1: While reset is asserted and just after it, flush, epc_load and retire are 0 and every squash bit is 0.
- R2: A fault strobe on stage k (0=fetch, 1=decode, 2=execute, 3=memory; code in flt_code[k*CW +: CW]) marks the valid instruction in that slot. squash[k] is 1 in that cycle, and the instruction reaches writeback on the fourth advance after it entered fetch without triggering anything earlier.
- R3: If one instruction is flagged in several stages, the cause reported at writeback is the code of the earliest detection.
- R4: When a marked instruction is in writeback, flush and epc_load are 1, redirect_pc equals HANDLER_PC (default 0x8000_0180), epc_val is that instruction's own address, cause_val is its code, and all four squash bits are 1.
- R5: A marked instruction in writeback never asserts retire.
- R6: Faults from instructions younger than the one being taken are discarded and never cause a second flush.
- R7: Unmarked instructions older than a faulting one retire normally, one cycle each, before the flush.
- R8: With irq high and a valid unmarked instruction in writeback, flush and epc_load are 1, cause_val is INT_CODE (default 0), epc_val is that instruction's address plus INSN_BYTES, and retire is 1.
- R9: When irq is high and the writeback instruction is marked, the fault wins: cause_val is the tag code and epc_val is the instruction's own address.
- R10: irq has no effect while the writeback slot is empty.
- R11: While advance is 0, the slots hold their contents, and a fault raised during the stall is kept on the instruction.
- R12: In the cycle after a flush every slot is empty, and an instruction fetched during the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Pipeline moves one stage this cycle |
| fetch_vld | input | 1 | An instruction enters the fetch slot on advance |
| fetch_pc | input | AW | Address of that instruction |
| flt_vld | input | 4 | Per-stage fault strobes, bit 0 = fetch … bit 3 = memory |
| flt_code | input | 4*CW | Per-stage cause codes, stage k at [k*CW +: CW] |
| irq | input | 1 | External interrupt request |
| squash | output | 4 | Suppress architectural effects per slot (bit 3 blocks a store) |
| flush | output | 1 | Invalidate fetch through memory slots and redirect fetch |
| redirect_pc | output | AW | Handler entry address used on flush |
| epc_load | output | 1 | Load the exception-PC and cause registers |
| epc_val | output | AW | Value for the exception-PC register |
| cause_val | output | CW | Value for the cause register |
| retire | output | 1 | Writeback instruction completes and may write its results |

## Verification
The bench uses the default parameters: 32-bit addresses, 5-bit codes, the handler entry at 0x8000_0180 and a 4-byte instruction size. With these values it can place faults in every one of the four detecting stages, overlap an older fault with a younger one, and keep a tag alive through a two-cycle stall. It can also line up an interrupt with an empty, a clean and a marked writeback slot.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;
    localparam int unsigned NSTG = 5;

    typedef enum logic [2:0] {
        STG_IF  = 3'd0,
        STG_ID  = 3'd1,
        STG_EX  = 3'd2,
        STG_MEM = 3'd3,
        STG_WB  = 3'd4
    } stage_e;
endpackage

// File: rtl/exc_tag_merge.sv
module exc_tag_merge #(
    parameter int unsigned CW = 5
) (
    input  logic          in_vld,
    input  logic          in_exc,
    input  logic [CW-1:0] in_cause,
    input  logic          flt,
    input  logic [CW-1:0] flt_code,
    output logic          out_exc,
    output logic [CW-1:0] out_cause
);
    logic fresh;

    always_comb begin
        fresh     = in_vld && !in_exc && flt;
        out_exc   = in_exc || fresh;
        out_cause = fresh ? flt_code : in_cause;
    end
endmodule

// File: rtl/exc_wb_resolve.sv
module exc_wb_resolve #(
    parameter int unsigned AW         = 32,
    parameter int unsigned CW         = 5,
    parameter logic [CW-1:0] INT_CODE = '0,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic          wb_vld,
    input  logic          wb_exc,
    input  logic [CW-1:0] wb_cause,
    input  logic [AW-1:0] wb_pc,
    input  logic          irq,
    input  logic          advance,
    output logic          take,
    output logic          retire,
    output logic [AW-1:0] epc,
    output logic [CW-1:0] cause
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic take_fault;
    logic take_irq;

    always_comb begin
        take_fault = wb_vld && wb_exc;
        take_irq   = wb_vld && !wb_exc && irq;
        take       = take_fault || take_irq;
        retire     = wb_vld && !wb_exc && (advance || take_irq);
        if (take_fault) begin
            epc   = wb_pc;
            cause = wb_cause;
        end else begin
            epc   = wb_pc + STEP;
            cause = INT_CODE;
        end
    end
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit #(
    parameter int unsigned AW           = 32,
    parameter int unsigned CW           = 5,
    parameter logic [AW-1:0] HANDLER_PC = 32'h8000_0180,
    parameter logic [CW-1:0] INT_CODE   = '0,
    parameter int unsigned INSN_BYTES   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic               fetch_vld,
    input  logic [AW-1:0]      fetch_pc,
    input  logic [3:0]         flt_vld,
    input  logic [4*CW-1:0]    flt_code,
    input  logic               irq,
    output logic [3:0]         squash,
    output logic               flush,
    output logic [AW-1:0]      redirect_pc,
    output logic               epc_load,
    output logic [AW-1:0]      epc_val,
    output logic [CW-1:0]      cause_val,
    output logic               retire
);
    import exc_commit_pkg::*;

    localparam int unsigned NFS = NSTG - 1;

    typedef struct packed {
        logic          vld;
        logic          exc;
        logic [CW-1:0] cause;
        logic [AW-1:0] pc;
    } slot_t;

    slot_t [NSTG-1:0] st_d, st_q, eff;

    logic [NFS-1:0] m_exc;
    logic [CW-1:0]  m_cause [NFS];
    logic           take;

    logic [NSTG-1:0] vld_vec;
    logic [NSTG-1:0] tag_vec;

    // Tag merge for every stage that may detect a fault
    for (genvar g = 0; g < NFS; g++) begin : g_merge
        exc_tag_merge #(.CW(CW)) u_merge (
            .in_vld   (st_q[g].vld),
            .in_exc   (st_q[g].exc),
            .in_cause (st_q[g].cause),
            .flt      (flt_vld[g]),
            .flt_code (flt_code[g*CW +: CW]),
            .out_exc  (m_exc[g]),
            .out_cause(m_cause[g])
        );
    end

    exc_wb_resolve #(
        .AW(AW), .CW(CW), .INT_CODE(INT_CODE), .INSN_BYTES(INSN_BYTES)
    ) u_resolve (
        .wb_vld  (st_q[STG_WB].vld),
        .wb_exc  (st_q[STG_WB].exc),
        .wb_cause(st_q[STG_WB].cause),
        .wb_pc   (st_q[STG_WB].pc),
        .irq     (irq),
        .advance (advance),
        .take    (take),
        .retire  (retire),
        .epc     (epc_val),
        .cause   (cause_val)
    );

    always_comb begin
        for (int k = 0; k < NFS; k++) begin
            eff[k].vld   = st_q[k].vld;
            eff[k].exc   = m_exc[k];
            eff[k].cause = m_cause[k];
            eff[k].pc    = st_q[k].pc;
        end
        eff[STG_WB] = st_q[STG_WB];

        st_d = st_q;
        if (take) begin
            st_d = '0;
        end else if (advance) begin
            st_d[STG_IF].vld   = fetch_vld;
            st_d[STG_IF].exc   = 1'b0;
            st_d[STG_IF].cause = '0;
            st_d[STG_IF].pc    = fetch_pc;
            for (int k = 1; k < NSTG; k++) begin
                st_d[k] = eff[k-1];
            end
        end else begin
            for (int k = 0; k < NFS; k++) begin
                st_d[k] = eff[k];
            end
        end

        for (int k = 0; k < NFS; k++) begin
            squash[k] = take || eff[k].exc;
        end
        for (int k = 0; k < NSTG; k++) begin
            vld_vec[k] = st_q[k].vld;
            tag_vec[k] = st_q[k].exc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush       = take;
    assign epc_load    = take;
    assign redirect_pc = HANDLER_PC;
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
    parameter int unsigned AW           = 32,
    parameter logic [AW-1:0] HANDLER_PC = 32'h8000_0180
) (
    input logic          clk,
    input logic          rst_n,
    input logic          advance,
    input logic          irq,
    input logic          flush,
    input logic          epc_load,
    input logic          retire,
    input logic [3:0]    squash,
    input logic [AW-1:0] redirect_pc,
    input logic [4:0]    vld_q,
    input logic [4:0]    tag_q
);
    // R4: a flush steers fetch to the handler and kills all younger slots
    a_r4_handler_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redirect_pc == HANDLER_PC && squash == 4'hF && epc_load));

    // R12: the pipe is empty right after a flush
    a_r12_drained_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!flush && !retire && vld_q == 5'b0));

    // R10: nothing is taken without an occupied writeback slot
    a_r10_take_needs_wb: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> vld_q[4]);

    // R5: a fault taken without an interrupt never retires
    a_r5_tagged_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !irq) |-> !retire);

    // R11: a stall never loses a tag
    a_r11_tags_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !flush) |=> ((tag_q & $past(tag_q)) == $past(tag_q)));

    // R2: a tag stored in execute moves on to memory
    a_r2_tag_travels: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !flush && tag_q[2]) |=> tag_q[3]);
endmodule

bind exc_commit_unit exc_commit_chk #(
    .AW(AW), .HANDLER_PC(HANDLER_PC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .irq        (irq),
    .flush      (flush),
    .epc_load   (epc_load),
    .retire     (retire),
    .squash     (squash),
    .redirect_pc(redirect_pc),
    .vld_q      (vld_vec),
    .tag_q      (tag_vec)
);

// File: tb/exc_commit_unit_tb.sv
module exc_commit_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 5;
    localparam logic [AW-1:0] HANDLER = 32'h8000_0180;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          advance = 1'b1;
    logic          fetch_vld = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [3:0]    flt_vld = '0;
    logic [4*CW-1:0] flt_code = '0;
    logic          irq = 1'b0;
    logic [3:0]    squash;
    logic          flush;
    logic [AW-1:0] redirect_pc;
    logic          epc_load;
    logic [AW-1:0] epc_val;
    logic [CW-1:0] cause_val;
    logic          retire;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_commit_unit u_dut (
        .clk(clk), .rst_n(rst_n), .advance(advance), .fetch_vld(fetch_vld),
        .fetch_pc(fetch_pc), .flt_vld(flt_vld), .flt_code(flt_code), .irq(irq),
        .squash(squash), .flush(flush), .redirect_pc(redirect_pc),
        .epc_load(epc_load), .epc_val(epc_val), .cause_val(cause_val),
        .retire(retire)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [4*CW-1:0] code_at(input int k, input logic [CW-1:0] c);
        logic [4*CW-1:0] v = '0;
        v[k*CW +: CW] = c;
        return v;
    endfunction

    // Apply one cycle of inputs after the edge, then stop at the falling edge
    task automatic cyc(input logic fv, input logic [AW-1:0] pc, input logic [3:0] fm,
                       input logic [4*CW-1:0] codes, input logic ir, input logic adv);
        @(posedge clk); #1;
        fetch_vld = fv; fetch_pc = pc; flt_vld = fm; flt_code = codes;
        irq = ir; advance = adv;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) cyc(1'b0, '0, 4'b0, '0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 flush in reset", flush, 0);
        chk("R1 retire in reset", retire, 0);
        chk("R1 squash in reset", squash, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 epc_load after reset", epc_load, 0);
    endtask

    task automatic t_ex_fault();
        cyc(1, 32'h100, 4'b0, '0, 0, 1);
        cyc(1, 32'h104, 4'b0, '0, 0, 1);
        cyc(1, 32'h108, 4'b0, '0, 0, 1);
        cyc(1, 32'h10C, 4'b0, '0, 0, 1);
        cyc(1, 32'h110, 4'b0100, code_at(2, 5'd12), 0, 1);
        chk("R2 squash execute", squash, 4'b0100);
        chk("R2 no early flush", flush, 0);
        cyc(1, 32'h114, 4'b0100, code_at(2, 5'd4), 0, 1);
        chk("R7 older retires", retire, 1);
        chk("R7 no flush yet", flush, 0);
        cyc(1, 32'h118, 4'b0, '0, 0, 1);
        chk("R4 flush", flush, 1);
        chk("R4 epc_load", epc_load, 1);
        chk("R4 redirect", redirect_pc, HANDLER);
        chk("R4 epc", epc_val, 32'h104);
        chk("R4 cause", cause_val, 5'd12);
        chk("R4 squash all", squash, 4'hF);
        chk("R5 tagged no retire", retire, 0);
        for (int i = 0; i < 6; i++) begin
            cyc(0, '0, 4'b0, '0, 0, 1);
            chk("R6 younger fault dropped", flush, 0);
            chk("R12 pipe empty", retire, 0);
        end
    endtask

    task automatic t_earliest();
        drain();
        cyc(1, 32'h200, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0001, code_at(0, 5'd6), 0, 1);
        chk("R2 squash fetch", squash, 4'b0001);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b1000, code_at(3, 5'd13), 0, 1);
        chk("R3 store blocked", squash[3], 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        chk("R3 flush", flush, 1);
        chk("R3 earliest cause", cause_val, 5'd6);
        chk("R3 epc", epc_val, 32'h200);
    endtask

    task automatic t_irq();
        drain();
        cyc(1, 32'h300, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 1, 1);
        chk("R10 irq with empty wb", flush, 0);
        cyc(0, '0, 4'b0, '0, 1, 1);
        chk("R8 irq flush", flush, 1);
        chk("R8 irq epc", epc_val, 32'h304);
        chk("R8 irq cause", cause_val, 5'd0);
        chk("R8 irq retire", retire, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        chk("R12 after irq", flush, 0);
    endtask

    task automatic t_priority();
        drain();
        cyc(1, 32'h500, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0010, code_at(1, 5'd9), 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 1, 1);
        chk("R9 flush", flush, 1);
        chk("R9 fault cause wins", cause_val, 5'd9);
        chk("R9 own epc", epc_val, 32'h500);
        chk("R9 no retire", retire, 0);
    endtask

    task automatic t_stall();
        drain();
        cyc(1, 32'h400, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0010, code_at(1, 5'd10), 0, 0);
        chk("R11 squash decode", squash, 4'b0010);
        cyc(0, '0, 4'b0, '0, 0, 0);
        chk("R11 tag kept in stall", squash, 4'b0010);
        chk("R11 no flush in stall", flush, 0);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        cyc(0, '0, 4'b0, '0, 0, 1);
        chk("R11 not yet", flush, 0);
        cyc(0, '0, 4'b0, '0, 0, 1);
        chk("R11 flush after stall", flush, 1);
        chk("R11 cause", cause_val, 5'd10);
        chk("R11 epc", epc_val, 32'h400);
    endtask

    initial begin
        t_reset();
        t_ex_fault();
        t_earliest();
        t_irq();
        t_priority();
        t_stall();
        drain();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule